// File: doc/BRIEF.md
# Hashed Inverted Page Table Walker

This block turns a virtual page number, tagged with a process identifier, into a physical address. It keeps a translation table with exactly one entry for every physical frame, so the table's size depends only on how many frames there are. It does not grow with the number of processes or with the size of the virtual space. Each entry holds a page number, a process identifier, a valid flag and a link to the next entry in its collision chain. Because the table is indexed by frame, the index of the entry that matches is itself the physical frame number.

A lookup folds the page number with XOR down to an entry index and starts there. It then examines one entry per clock cycle and follows the chain links until one of three things happens:

- a valid entry with the same page and process is found, which gives a hit;
- the chain ends, which gives a fault;
- as many entries as there are frames have been examined, which also gives a fault.

The in-page offset goes through unchanged. Entries are loaded through a write port. While a walk is in progress the request side is held off by a low ready.

Top module: `ipt_lookup`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, and every entry reads as invalid with a null link.
- R2: The first entry examined is the XOR of the page number cut into `$clog2(FRAMES)`-bit groups, starting at bit 0, with the top group zero-padded. With 16 frames and a 20-bit page number this is the XOR of its five nibbles.
- R3: An entry matches when its valid flag is 1 and both its page number and its process identifier equal the request. A match gives `rsp_hit`=1, `rsp_fault`=0, and the frame field set to that entry's index. `rsp_hit` and `rsp_fault` are never both set.
- R4: When an entry does not match, the walk moves to the entry named by its link. A link of all ones (15 with 16 frames) is null: the walk ends there with `rsp_fault`=1.
- R5: An entry whose valid flag is 0 never matches, even when its page number and process identifier equal the request.
- R6: `rsp_paddr` is {frame, offset}. The frame field occupies the upper `$clog2(FRAMES)` bits and the offset occupies the low `OFF_W` bits, copied unchanged from `req_off`. On a fault the frame field is 0.
- R7: One entry is examined per cycle. When a request is accepted on a rising edge and k entries are examined, `rsp_valid` is 1 for exactly the one cycle after the k-th following rising edge. `rsp_valid` is never set without an accepted request.
- R8: A walk that has examined `FRAMES` entries without a match ends with a fault, so a chain that loops back on itself still terminates.
- R9: `req_ready` is 0 from the cycle after a request is accepted until the response cycle. During that time a waiting request is not taken. It is accepted on the first rising edge at which `req_ready` is 1.
- R10: When `wr_en`=1 at a rising edge, the entry at `wr_idx` is replaced by (`wr_vpn`, `wr_pid`, `wr_vld`, `wr_link`). Lookups accepted after that edge see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Engine idle, request will be taken |
| req_vpn | input | VPN_W | Virtual page number |
| req_pid | input | PID_W | Process identifier |
| req_off | input | OFF_W | Offset within the page |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Translation found |
| rsp_fault | output | 1 | Chain ended or step limit reached without a match |
| rsp_paddr | output | $clog2(FRAMES)+OFF_W | Frame number joined with the offset |
| wr_en | input | 1 | Write one table entry |
| wr_idx | input | $clog2(FRAMES) | Entry (frame) to write |
| wr_vpn | input | VPN_W | Page number stored in the entry |
| wr_pid | input | PID_W | Process identifier stored in the entry |
| wr_vld | input | 1 | Valid flag stored in the entry |
| wr_link | input | $clog2(FRAMES) | Next entry in the chain, all ones for none |

## Verification
Each kind of wrong internal state shows up at the ports in its own way:

- A wrong starting index, a broken link follow or a bad compare shows in the frame field of the next response, or as a fault where a hit was expected.
- A stuck or mis-counted step counter shows as a response that arrives on a different edge than the number of entries examined. A looping chain then answers after a time other than `FRAMES` cycles, or never answers.
- A state machine that leaves its walk state too early or too late shows within one cycle as `req_ready` out of step with `rsp_valid`. It can also show as a held request being taken while a walk is still running.

The bench measures the response latency of every lookup and checks the frame and offset bit by bit, so each of these faults surfaces on the first lookup that passes through it.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  // Walk controller states
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walk_st_e;
endpackage

// File: rtl/ipt_table.sv
// Frame-indexed translation storage: one entry per physical frame.
module ipt_table #(
  parameter int FRAMES = 16,
  parameter int VPN_W  = 20,
  parameter int PID_W  = 4,
  localparam int IDX_W = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PID_W-1:0] wr_pid,
  input  logic             wr_vld,
  input  logic [IDX_W-1:0] wr_link,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [VPN_W-1:0] rd_vpn,
  output logic [PID_W-1:0] rd_pid,
  output logic             rd_vld,
  output logic [IDX_W-1:0] rd_link
);
  logic [VPN_W-1:0] vpn_q  [FRAMES];
  logic [PID_W-1:0] pid_q  [FRAMES];
  logic             vld_q  [FRAMES];
  logic [IDX_W-1:0] link_q [FRAMES];

  for (genvar e = 0; e < FRAMES; e++) begin : g_entry
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vpn_q[e]  <= '0;
        pid_q[e]  <= '0;
        vld_q[e]  <= 1'b0;
        link_q[e] <= '1;
      end else if (sel) begin
        vpn_q[e]  <= wr_vpn;
        pid_q[e]  <= wr_pid;
        vld_q[e]  <= wr_vld;
        link_q[e] <= wr_link;
      end
    end
  end

  assign rd_vpn  = vpn_q[rd_idx];
  assign rd_pid  = pid_q[rd_idx];
  assign rd_vld  = vld_q[rd_idx];
  assign rd_link = link_q[rd_idx];
endmodule

// File: rtl/ipt_match.sv
// Tag compare for the entry under examination.
module ipt_match #(
  parameter int VPN_W = 20,
  parameter int PID_W = 4
) (
  input  logic [VPN_W-1:0] ent_vpn,
  input  logic [PID_W-1:0] ent_pid,
  input  logic             ent_vld,
  input  logic [VPN_W-1:0] key_vpn,
  input  logic [PID_W-1:0] key_pid,
  output logic             hit
);
  assign hit = ent_vld && (ent_vpn == key_vpn) && (ent_pid == key_pid);
endmodule

// File: rtl/ipt_walker.sv
// Hash, chain-follow and step-limit control; registers the response.
module ipt_walker
  import ipt_pkg::*;
#(
  parameter int FRAMES = 16,
  parameter int VPN_W  = 20,
  parameter int PID_W  = 4,
  parameter int OFF_W  = 12,
  localparam int IDX_W = $clog2(FRAMES),
  localparam int PA_W  = IDX_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [PID_W-1:0] req_pid,
  input  logic [OFF_W-1:0] req_off,
  output logic [VPN_W-1:0] key_vpn,
  output logic [PID_W-1:0] key_pid,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [IDX_W-1:0] rd_link,
  input  logic             ent_match,
  output logic             walking,
  output logic [IDX_W-1:0] step_cnt,
  output logic             chain_end,
  output logic             cap_hit,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr
);
  localparam int NGRP = (VPN_W + IDX_W - 1) / IDX_W;
  localparam logic [IDX_W-1:0] NULL_IDX = '1;
  localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(FRAMES - 1);

  // XOR-fold of the page number into an entry index
  function automatic logic [IDX_W-1:0] fold_vpn(input logic [VPN_W-1:0] v);
    logic [NGRP*IDX_W-1:0] padded;
    logic [IDX_W-1:0]      acc;
    padded = '0;
    padded[VPN_W-1:0] = v;
    acc = '0;
    for (int g = 0; g < NGRP; g++) acc ^= padded[g*IDX_W +: IDX_W];
    return acc;
  endfunction

  walk_st_e         state_q;
  logic [IDX_W-1:0] cur_q;
  logic [IDX_W-1:0] step_q;
  logic [OFF_W-1:0] off_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PID_W-1:0] pid_q;

  assign walking   = (state_q == ST_WALK);
  assign req_ready = !walking;
  assign rd_idx    = cur_q;
  assign key_vpn   = vpn_q;
  assign key_pid   = pid_q;
  assign step_cnt  = step_q;
  assign chain_end = (rd_link == NULL_IDX);
  assign cap_hit   = (step_q == LAST_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cur_q     <= '0;
      step_q    <= '0;
      off_q     <= '0;
      vpn_q     <= '0;
      pid_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            vpn_q   <= req_vpn;
            pid_q   <= req_pid;
            off_q   <= req_off;
            cur_q   <= fold_vpn(req_vpn);
            step_q  <= '0;
            state_q <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (ent_match) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b1;
            rsp_fault <= 1'b0;
            rsp_paddr <= {cur_q, off_q};
            state_q   <= ST_IDLE;
          end else if (chain_end || cap_hit) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b1;
            rsp_paddr <= {{IDX_W{1'b0}}, off_q};
            state_q   <= ST_IDLE;
          end else begin
            cur_q  <= rd_link;
            step_q <= step_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ipt_lookup.sv
// Top: hashed, frame-indexed translation lookup engine.
module ipt_lookup #(
  parameter int FRAMES = 16,
  parameter int VPN_W  = 20,
  parameter int PID_W  = 4,
  parameter int OFF_W  = 12,
  localparam int IDX_W = $clog2(FRAMES),
  localparam int PA_W  = IDX_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [PID_W-1:0] req_pid,
  input  logic [OFF_W-1:0] req_off,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PID_W-1:0] wr_pid,
  input  logic             wr_vld,
  input  logic [IDX_W-1:0] wr_link
);
  logic [IDX_W-1:0] rd_idx;
  logic [VPN_W-1:0] rd_vpn;
  logic [PID_W-1:0] rd_pid;
  logic             rd_vld;
  logic [IDX_W-1:0] rd_link;
  logic [VPN_W-1:0] key_vpn;
  logic [PID_W-1:0] key_pid;
  logic             ent_match;
  logic             walking;
  logic [IDX_W-1:0] step_cnt;
  logic             chain_end;
  logic             cap_hit;

  ipt_table #(.FRAMES(FRAMES), .VPN_W(VPN_W), .PID_W(PID_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_pid(wr_pid),
    .wr_vld(wr_vld), .wr_link(wr_link),
    .rd_idx(rd_idx), .rd_vpn(rd_vpn), .rd_pid(rd_pid), .rd_vld(rd_vld),
    .rd_link(rd_link)
  );

  ipt_match #(.VPN_W(VPN_W), .PID_W(PID_W)) u_match (
    .ent_vpn(rd_vpn), .ent_pid(rd_pid), .ent_vld(rd_vld),
    .key_vpn(key_vpn), .key_pid(key_pid), .hit(ent_match)
  );

  ipt_walker #(.FRAMES(FRAMES), .VPN_W(VPN_W), .PID_W(PID_W), .OFF_W(OFF_W)) u_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_pid(req_pid), .req_off(req_off),
    .key_vpn(key_vpn), .key_pid(key_pid),
    .rd_idx(rd_idx), .rd_link(rd_link), .ent_match(ent_match),
    .walking(walking), .step_cnt(step_cnt),
    .chain_end(chain_end), .cap_hit(cap_hit),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr)
  );
endmodule

// File: rtl/ipt_lookup_chk.sv
// Protocol and response checks, attached to the top by bind.
module ipt_lookup_chk #(
  parameter int FRAMES = 16,
  localparam int IDX_W = $clog2(FRAMES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_fault,
  input logic [IDX_W-1:0] rsp_frame,
  input logic             walking,
  input logic             ent_match,
  input logic             chain_end,
  input logic             cap_hit
);
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);  // R7

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !walking |=> !rsp_valid);  // R7

  AST_HIT_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != rsp_fault));  // R3

  AST_MATCH_ENDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    walking && ent_match |=> rsp_valid && rsp_hit);  // R3

  AST_END_OR_CAP_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    walking && !ent_match && (chain_end || cap_hit) |=> rsp_valid && rsp_fault);  // R8

  AST_FAULT_FRAME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_frame == '0);  // R6

  AST_STALL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);  // R9

  AST_READY_AT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);  // R9
endmodule

bind ipt_lookup ipt_lookup_chk #(.FRAMES(FRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
  .rsp_frame(rsp_paddr[PA_W-1:OFF_W]),
  .walking(walking), .ent_match(ent_match),
  .chain_end(chain_end), .cap_hit(cap_hit)
);

// File: tb/ipt_lookup_tb.sv
module ipt_lookup_tb;
  localparam int FRAMES = 16;
  localparam int VPN_W  = 20;
  localparam int PID_W  = 4;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 4;
  localparam int PA_W   = IDX_W + OFF_W;
  localparam logic [IDX_W-1:0] NUL = 4'hF;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [VPN_W-1:0] req_vpn = '0;
  logic [PID_W-1:0] req_pid = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic             rsp_valid, rsp_hit, rsp_fault;
  logic [PA_W-1:0]  rsp_paddr;
  logic             wr_en = 1'b0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [VPN_W-1:0] wr_vpn = '0;
  logic [PID_W-1:0] wr_pid = '0;
  logic             wr_vld = 1'b0;
  logic [IDX_W-1:0] wr_link = '0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ipt_lookup #(.FRAMES(FRAMES), .VPN_W(VPN_W), .PID_W(PID_W), .OFF_W(OFF_W)) u_dut (.*);

  // Stimulus / expectation table, walked by one loop
  localparam int NV = 10;
  localparam logic [VPN_W-1:0] V_VPN [NV] = '{20'h00003, 20'h00013, 20'h00013, 20'h00005, 20'h12345,
                                              20'h0000A, 20'h0000B, 20'h0000F, 20'h00002, 20'h0000A};
  localparam logic [PID_W-1:0] V_PID [NV] = '{4'd1, 4'd2, 4'd1, 4'd1, 4'd5, 4'd3, 4'd3, 4'd0, 4'd1, 4'd4};
  localparam logic [OFF_W-1:0] V_OFF [NV] = '{12'h0AB, 12'hFFF, 12'h123, 12'h001, 12'h800,
                                              12'h000, 12'h555, 12'h7FF, 12'h3C3, 12'h444};
  localparam bit               V_HIT [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic [IDX_W-1:0] V_FRM [NV] = '{4'd3, 4'd7, 4'd0, 4'd0, 4'd1, 4'd10, 4'd11, 4'd15, 4'd2, 4'd0};
  localparam int               V_LAT [NV] = '{1, 2, 2, 1, 1, 1, 1, 1, 1, 16};
  string v_tag [NV] = '{"R3 direct hit", "R4 chain follow", "R4 null link fault", "R5 invalid entry",
                        "R2 folded hash", "R3 loop member hit", "R3 second loop member",
                        "R6 all-ones head entry", "R3 chain head hit", "R8 looping chain cap"};

  // Bench restatement of the index fold: bit i lands in index bit i mod IDX_W
  function automatic logic [IDX_W-1:0] tb_hash(input logic [VPN_W-1:0] v);
    logic [IDX_W-1:0] h = '0;
    for (int i = 0; i < VPN_W; i++) h[i % IDX_W] ^= v[i];
    return h;
  endfunction

  task automatic check(input string tag, input bit ok, input string got, input string exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %s expected %s", tag, got, exp);
    end
  endtask

  task automatic write_entry(input logic [IDX_W-1:0] idx, input logic [VPN_W-1:0] vpn,
                             input logic [PID_W-1:0] pid, input logic vld,
                             input logic [IDX_W-1:0] lnk);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_pid = pid; wr_vld = vld; wr_link = lnk;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Issue one lookup from idle; return latency in rising edges after acceptance
  task automatic lookup(input logic [VPN_W-1:0] vpn, input logic [PID_W-1:0] pid,
                        input logic [OFF_W-1:0] off, output int lat);
    @(negedge clk);
    req_vpn = vpn; req_pid = pid; req_off = off; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_rsp(input string tag, input bit exp_hit, input logic [IDX_W-1:0] exp_frm,
                           input logic [OFF_W-1:0] off, input int lat, input int exp_lat);
    logic [PA_W-1:0] exp_pa;
    exp_pa = exp_hit ? {exp_frm, off} : {{IDX_W{1'b0}}, off};
    check(tag, rsp_valid && rsp_hit == exp_hit && rsp_fault == !exp_hit,
          $sformatf("v%0b h%0b f%0b", rsp_valid, rsp_hit, rsp_fault),
          $sformatf("v1 h%0b f%0b", exp_hit, !exp_hit));
    check({tag, " paddr R6"}, rsp_paddr == exp_pa,
          $sformatf("%h", rsp_paddr), $sformatf("%h", exp_pa));
    check({tag, " latency R7"}, lat == exp_lat,
          $sformatf("%0d", lat), $sformatf("%0d", exp_lat));
    @(negedge clk);
    check({tag, " pulse R7"}, !rsp_valid, $sformatf("%0b", rsp_valid), "0");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    int lat;
    logic [IDX_W-1:0] h;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ready after reset", req_ready == 1'b1, $sformatf("%0b", req_ready), "1");
    check("R1 no response in reset", rsp_valid == 1'b0, $sformatf("%0b", rsp_valid), "0");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready out of reset", req_ready && !rsp_valid,
          $sformatf("r%0b v%0b", req_ready, rsp_valid), "r1 v0");
    // R1: table empty, any lookup faults on the first entry
    lookup(20'h00003, 4'd1, 12'h111, lat);
    check_rsp("R1 empty table", 1'b0, '0, 12'h111, lat, 1);

    // Load table (R10 write port)
    write_entry(4'd3,  20'h00003, 4'd1, 1'b1, NUL);
    write_entry(4'd2,  20'h00002, 4'd1, 1'b1, 4'd7);
    write_entry(4'd7,  20'h00013, 4'd2, 1'b1, NUL);
    write_entry(4'd5,  20'h00005, 4'd1, 1'b0, NUL);
    write_entry(4'd1,  20'h12345, 4'd5, 1'b1, NUL);
    write_entry(4'd10, 20'h0000A, 4'd3, 1'b1, 4'd11);
    write_entry(4'd11, 20'h0000B, 4'd3, 1'b1, 4'd10);
    write_entry(4'd15, 20'h0000F, 4'd0, 1'b1, NUL);

    for (int k = 0; k < NV; k++) begin
      lookup(V_VPN[k], V_PID[k], V_OFF[k], lat);
      check_rsp(v_tag[k], V_HIT[k], V_FRM[k], V_OFF[k], lat, V_LAT[k]);
    end

    // R2: place an entry at the bench-computed fold of a dense page number
    h = tb_hash(20'hABCDE);
    write_entry(h, 20'hABCDE, 4'd6, 1'b1, NUL);
    lookup(20'hABCDE, 4'd6, 12'h9A5, lat);
    check_rsp("R2 fold of ABCDE", 1'b1, h, 12'h9A5, lat, 1);

    // R9: hold a second request while a long walk runs
    @(negedge clk);
    req_vpn = 20'h0000A; req_pid = 4'd4; req_off = 12'h321; req_valid = 1'b1;
    @(negedge clk);
    req_vpn = 20'h00003; req_pid = 4'd1; req_off = 12'hABC;
    check("R9 stalled during walk", req_ready == 1'b0, $sformatf("%0b", req_ready), "0");
    lat = 0;
    while (!rsp_valid && lat < 100) begin
      @(negedge clk);
      lat++;
      if (!rsp_valid && req_ready)
        check("R9 ready while walking", 1'b0, "1", "0");
    end
    check("R9 first response is the loop fault", rsp_fault && lat == 16,
          $sformatf("f%0b lat%0d", rsp_fault, lat), "f1 lat16");
    check("R9 ready at response", req_ready == 1'b1, $sformatf("%0b", req_ready), "1");
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check_rsp("R9 held request served", 1'b1, 4'd3, 12'hABC, lat, 1);

    // R10: invalidate an entry, then re-validate it under another process
    write_entry(4'd3, 20'h00003, 4'd1, 1'b0, NUL);
    lookup(20'h00003, 4'd1, 12'h0F0, lat);
    check_rsp("R10 invalidated entry", 1'b0, '0, 12'h0F0, lat, 1);
    write_entry(4'd3, 20'h00003, 4'd9, 1'b1, NUL);
    lookup(20'h00003, 4'd9, 12'h00F, lat);
    check_rsp("R10 rewritten entry", 1'b1, 4'd3, 12'h00F, lat, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule